// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter Bank

This block decides, for each received CAN frame, whether the frame is kept for storage. A frame-complete strobe comes with the 29-bit identifier, the identifier-extension flag and the remote-request flag. The block turns these into a 31-bit comparison key and checks the key against eight programmable code/mask pairs in parallel. One clock later it reports a keep/drop decision and a 4-bit hit code, which is stored with the message.

A global enable selects the mode. While the enable is low, the bank passes every valid frame with hit code 0000. While it is high, a frame is kept only if at least one filter accepts it. The lowest-numbered accepting filter then names itself in the hit code.

A two-state controller runs the result timing. ST_IDLE shows no result. The transition ST_IDLE -> ST_SHOW is taken on a strobe. ST_SHOW -> ST_SHOW is taken when a further strobe arrives in the result cycle (back-to-back frames). ST_SHOW -> ST_IDLE is taken when no strobe arrives. The result fields are latched in the strobe cycle.

Top module: `can_id_filter_bank`

## Requirements
- R1: After reset, and while reset is held, out_valid and out_store are 0 and out_hit is 0000.
- R2: out_valid is 1 exactly in the cycle after each cycle in which frm_valid is 1. When out_valid is 0, out_store is 0 and out_hit is 0000, whatever the other inputs do.
- R3: When filt_en is 0 at the strobe, the result is out_store=1 and out_hit=0000 for every frame.
- R4: Each filter k uses code and mask bits [k*31 +: 31] of filt_code and filt_mask. The key layout is bit 30 = IDE, bit 29 = RTR, bits 28:0 = identifier. A mask bit of 1 requires that key bit to equal the code bit. A mask bit of 0 makes that key bit don't-care, so an all-zero mask accepts every frame.
- R5: A hit on filter k reports out_hit = 4'b1000 + k (filter 0 gives 1000, filter 7 gives 1111), with out_store=1.
- R6: When several filters accept a frame, the lowest-numbered one sets out_hit.
- R7: With filt_en at 1 and no filter accepting, the result is out_store=0 and out_hit=0000.
- R8: For a standard frame (IDE=0), the 11-bit identifier is taken from rx_id[28:18] and rx_id[17:0] is treated as zero before comparison.
- R9: IDE is part of the key, so a filter with code IDE=0 and mask IDE=1 never accepts an extended frame, and clearing that mask bit lets it accept both formats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle strobe: a valid frame is on the rx_* inputs |
| filt_en | input | 1 | Global filtering enable (0 = keep everything) |
| rx_id | input | 29 | Received identifier (standard ID in bits 28:18) |
| rx_ide | input | 1 | Received identifier-extension bit |
| rx_rtr | input | 1 | Received remote-request bit |
| filt_code | input | 248 | Eight 31-bit filter codes, filter k at [k*31 +: 31] |
| filt_mask | input | 248 | Eight 31-bit masks, filter k at [k*31 +: 31] |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_store | output | 1 | Keep the frame |
| out_hit | output | 4 | Hit code: 1000+k for filter k, 0000 for none or filtering off |

## Verification
The bench sends standard frames with junk in the low identifier bits. A design that kept those bits would miss the standard filters. It also sends frames accepted by two filters at once. A priority encoder that picks the highest index, or that mixes indices, would report the wrong code there. An extended frame with a standard filter's identifier bits must be rejected, and a filter whose IDE mask bit is clear must take both formats; this catches a design that drops IDE from the key. Back-to-back strobes, and input changes between strobes, expose result registers that are not latched at the strobe or that let results leak out while ST_IDLE is held.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

    localparam int ID_W   = 29;
    localparam int STD_W  = 11;
    localparam int EXT_W  = ID_W - STD_W;
    localparam int KEY_W  = ID_W + 2;
    localparam int KEY_IDE = KEY_W - 1;
    localparam int KEY_RTR = KEY_W - 2;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } res_state_t;

endpackage

// File: rtl/can_filt_key.sv
module can_filt_key
    import can_filt_pkg::*;
(
    input  logic [ID_W-1:0]  id_i,
    input  logic             ide_i,
    input  logic             rtr_i,
    output logic [KEY_W-1:0] key_o
);

    logic [EXT_W-1:0] low_bits;

    // Extended-only bits read as zero for standard frames.
    always_comb begin
        low_bits = ide_i ? id_i[EXT_W-1:0] : '0;
        key_o    = {ide_i, rtr_i, id_i[ID_W-1:EXT_W], low_bits};
    end

endmodule

// File: rtl/can_filt_match.sv
module can_filt_match #(
    parameter int W = 31
) (
    input  logic [W-1:0] key_i,
    input  logic [W-1:0] code_i,
    input  logic [W-1:0] mask_i,
    output logic         hit_o
);

    logic [W-1:0] diff;

    always_comb begin
        diff  = (key_i ^ code_i) & mask_i;
        hit_o = (diff == '0);
    end

endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top down so the lowest index is written last and wins.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/can_id_filter_bank.sv
module can_id_filter_bank
    import can_filt_pkg::*;
#(
    parameter int NUM_FILT = 8,
    localparam int IDX_W   = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1,
    localparam int HIT_W   = IDX_W + 1,
    localparam int BANK_W  = NUM_FILT * KEY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic              filt_en,
    input  logic [ID_W-1:0]   rx_id,
    input  logic              rx_ide,
    input  logic              rx_rtr,
    input  logic [BANK_W-1:0] filt_code,
    input  logic [BANK_W-1:0] filt_mask,
    output logic              out_valid,
    output logic              out_store,
    output logic [HIT_W-1:0]  out_hit
);

    logic [KEY_W-1:0]    key;
    logic [NUM_FILT-1:0] match_vec;
    logic                any_hit;
    logic [IDX_W-1:0]    win_idx;

    res_state_t          state_q, state_d;
    logic                store_q, store_d;
    logic [HIT_W-1:0]    hit_q, hit_d;

    can_filt_key u_key (
        .id_i  (rx_id),
        .ide_i (rx_ide),
        .rtr_i (rx_rtr),
        .key_o (key)
    );

    for (genvar k = 0; k < NUM_FILT; k++) begin : g_filt
        can_filt_match #(.W(KEY_W)) u_match (
            .key_i  (key),
            .code_i (filt_code[k*KEY_W +: KEY_W]),
            .mask_i (filt_mask[k*KEY_W +: KEY_W]),
            .hit_o  (match_vec[k])
        );
    end

    can_filt_prio #(.N(NUM_FILT), .IDX_W(IDX_W)) u_prio (
        .req_i (match_vec),
        .any_o (any_hit),
        .idx_o (win_idx)
    );

    // Decision for the frame currently on the inputs.
    always_comb begin
        if (!filt_en) begin
            store_d = 1'b1;
            hit_d   = '0;
        end else if (any_hit) begin
            store_d = 1'b1;
            hit_d   = {1'b1, win_idx};
        end else begin
            store_d = 1'b0;
            hit_d   = '0;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (frm_valid) state_d = ST_SHOW;
            ST_SHOW: state_d = frm_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and latched result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            store_q <= 1'b0;
            hit_q   <= '0;
        end else begin
            state_q <= state_d;
            if (frm_valid) begin
                store_q <= store_d;
                hit_q   <= hit_d;
            end
        end
    end

    // Outputs.
    always_comb begin
        out_valid = 1'b0;
        out_store = 1'b0;
        out_hit   = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SHOW: begin
                out_valid = 1'b1;
                out_store = store_q;
                out_hit   = hit_q;
            end
            default: ;
        endcase
    end

    // R2
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> out_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> (!out_valid && !out_store && out_hit == '0));

    // R3
    pass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !filt_en) |=> (out_store && out_hit == '0));

    // R7
    store_matches_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && filt_en) |=> (out_store == (out_hit != '0)));

    // R5
    hit_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hit != '0) |-> (out_hit[HIT_W-1] && out_valid && out_store));

    // R6
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && filt_en && match_vec[0]) |=> (out_hit == {1'b1, {IDX_W{1'b0}}}));

endmodule

// File: tb/can_id_filter_bank_bench.sv
module can_id_filter_bank_bench;

    localparam int CLK_P  = 10;
    localparam int NF     = 8;
    localparam int KW     = 31;
    localparam int NVEC   = 17;

    // {en, ide, rtr, id[28:0], exp_store, exp_hit[3:0]}
    localparam logic [36:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 29'h048FFFFF, 1'b1, 4'h8}, // R8 std 0x123, junk low bits
        {1'b1, 1'b0, 1'b1, 29'h048C0000, 1'b1, 4'h8}, // R6 F0 and F3 both accept
        {1'b1, 1'b0, 1'b1, 29'h00000000, 1'b1, 4'hB}, // R5 std remote -> F3
        {1'b1, 1'b1, 1'b0, 29'h01ABCDE0, 1'b1, 4'h9}, // R6 F1 and F2 both accept
        {1'b1, 1'b1, 1'b1, 29'h01ABCD55, 1'b1, 4'hA}, // R4 partial mask F2
        {1'b1, 1'b0, 1'b0, 29'h1FFC0000, 1'b1, 4'hC}, // R5 std 0x7FF -> F4
        {1'b1, 1'b1, 1'b0, 29'h1FFC1234, 1'b1, 4'hC}, // R9 IDE unmasked in F4
        {1'b1, 1'b1, 1'b1, 29'h00000001, 1'b1, 4'hD}, // R6 F5 over F6
        {1'b1, 1'b1, 1'b0, 29'h00000042, 1'b1, 4'hF}, // R5 filter 7
        {1'b1, 1'b1, 1'b1, 29'h00000042, 1'b1, 4'hF}, // R4 RTR don't-care
        {1'b1, 1'b0, 1'b0, 29'h00000042, 1'b0, 4'h0}, // R7 R8 std, low bits dropped
        {1'b1, 1'b1, 1'b0, 29'h048C0000, 1'b0, 4'h0}, // R9 ext vs std filter
        {1'b0, 1'b1, 1'b0, 29'h01234567, 1'b1, 4'h0}, // R3 filtering off
        {1'b0, 1'b0, 1'b0, 29'h00000000, 1'b1, 4'h0}, // R3 filtering off
        {1'b1, 1'b1, 1'b0, 29'h01234567, 1'b0, 4'h0}, // R7 no match
        {1'b1, 1'b1, 1'b1, 29'h01ABCDE0, 1'b1, 4'h9}, // R4 F1 RTR don't-care
        {1'b1, 1'b0, 1'b0, 29'h1FFFFFFF, 1'b1, 4'hC}  // R8 std 0x7FF, junk low bits
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              frm_valid;
    logic              filt_en;
    logic [28:0]       rx_id;
    logic              rx_ide;
    logic              rx_rtr;
    logic [NF*KW-1:0]  filt_code;
    logic [NF*KW-1:0]  filt_mask;
    logic              out_valid;
    logic              out_store;
    logic [3:0]        out_hit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    can_id_filter_bank u_can_id_filter_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .filt_en   (filt_en),
        .rx_id     (rx_id),
        .rx_ide    (rx_ide),
        .rx_rtr    (rx_rtr),
        .filt_code (filt_code),
        .filt_mask (filt_mask),
        .out_valid (out_valid),
        .out_store (out_store),
        .out_hit   (out_hit)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_res(input string tag, input logic v, input logic s, input logic [3:0] h);
        chk({tag, " valid"}, {7'b0, out_valid}, {7'b0, v});
        chk({tag, " store"}, {7'b0, out_store}, {7'b0, s});
        chk({tag, " hit"},   {4'b0, out_hit},   {4'b0, h});
    endtask

    task automatic put(input logic en, input logic ide, input logic rtr, input logic [28:0] id);
        filt_en   = en;
        rx_ide    = ide;
        rx_rtr    = rtr;
        rx_id     = id;
        frm_valid = 1'b1;
    endtask

    task automatic set_filt(input int k, input logic [30:0] c, input logic [30:0] m);
        filt_code[k*KW +: KW] = c;
        filt_mask[k*KW +: KW] = m;
    endtask

    initial begin
        rst_n = 1'b0; frm_valid = 1'b0; filt_en = 1'b0;
        rx_id = '0; rx_ide = 1'b0; rx_rtr = 1'b0;
        filt_code = '0; filt_mask = '1;
        set_filt(0, {1'b0, 1'b0, 29'h048C0000}, {1'b1, 1'b0, 29'h1FFC0000});
        set_filt(1, {1'b1, 1'b0, 29'h01ABCDE0}, {1'b1, 1'b0, 29'h1FFFFFFF});
        set_filt(2, {1'b1, 1'b0, 29'h01ABCD00}, {1'b1, 1'b0, 29'h1FFFFF00});
        set_filt(3, {1'b0, 1'b1, 29'h00000000}, {1'b1, 1'b1, 29'h00000000});
        set_filt(4, {1'b0, 1'b0, 29'h1FFC0000}, {1'b0, 1'b0, 29'h1FFC0000});
        set_filt(5, {1'b1, 1'b1, 29'h00000001}, 31'h7FFFFFFF);
        set_filt(6, {1'b1, 1'b1, 29'h00000001}, 31'h7FFFFFFF);
        set_filt(7, {1'b1, 1'b0, 29'h00000042}, {1'b1, 1'b0, 29'h1FFFFFFF});
        // R1: strobe while reset is held must not show a result
        @(negedge clk);
        put(1'b0, 1'b0, 1'b0, '0);
        repeat (3) @(negedge clk);
        chk_res("R1 in reset", 1'b0, 1'b0, 4'h0);
        frm_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk_res("R1 after reset", 1'b0, 1'b0, 4'h0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            put(VEC[i][36], VEC[i][35], VEC[i][34], VEC[i][33:5]);
            @(negedge clk);
            frm_valid = 1'b0;
            chk_res($sformatf("vec%0d R2 R4 R5", i), 1'b1, VEC[i][4], VEC[i][3:0]);
            @(negedge clk);
            chk_res($sformatf("vec%0d R2 gap", i), 1'b0, 1'b0, 4'h0);
        end

        // R2: back-to-back strobes, each result latched at its own strobe
        put(1'b1, 1'b1, 1'b0, 29'h00000042);
        @(negedge clk);
        put(1'b1, 1'b1, 1'b0, 29'h01234567);
        chk_res("R2 b2b first", 1'b1, 1'b1, 4'hF);
        @(negedge clk);
        frm_valid = 1'b0;
        rx_id = 29'h01ABCDE0;
        chk_res("R2 b2b second", 1'b1, 1'b0, 4'h0);
        // R2: inputs moving without strobe have no effect at the outputs
        @(negedge clk);
        filt_en = 1'b0; rx_ide = 1'b0; rx_id = 29'h048C0000;
        @(negedge clk);
        chk_res("R2 no strobe", 1'b0, 1'b0, 4'h0);

        // R4: all-zero mask on filter 0 accepts every frame
        set_filt(0, 31'h12345678, 31'h0);
        put(1'b1, 1'b1, 1'b1, 29'h01234567);
        @(negedge clk);
        frm_valid = 1'b0;
        chk_res("R4 zero mask", 1'b1, 1'b1, 4'h8);

        // R9: IDE mask bit cleared lets std filter take extended frames
        set_filt(0, {1'b0, 1'b0, 29'h048C0000}, {1'b0, 1'b0, 29'h1FFC0000});
        @(negedge clk);
        put(1'b1, 1'b1, 1'b0, 29'h048C0000);
        @(negedge clk);
        frm_valid = 1'b0;
        chk_res("R9 ide masked", 1'b1, 1'b1, 4'h8);

        // R1: reset clears a pending result
        @(negedge clk);
        put(1'b1, 1'b1, 1'b0, 29'h00000042);
        @(negedge clk);
        frm_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk_res("R1 reset clears", 1'b0, 1'b0, 4'h0);
        rst_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule